// File: doc/BRIEF.md
# DDR SDRAM Command Timing Guard

This block sits between the command scheduler of a memory controller and the command bus of a four-bank DDR SDRAM. The scheduler offers at most one command per cycle: bank activate, read, write (optionally with auto-precharge), precharge, auto refresh, mode register set or self-refresh exit. The guard checks the command against every timing minimum that applies, per bank and device-wide. A legal command is forwarded on registered outputs one cycle later. An illegal command is dropped, and each rule that blocked it sets a bit in a sticky violation vector.

All spacings are given in picoseconds and turned into clock cycles when the block is elaborated, rounding up, from a clock-period parameter. A speed-grade parameter picks between the faster and the slower set of values. The block also runs the periodic refresh interval and raises a refresh-due flag. It flags any row that stays open past the maximum allowed time.

Top module: `ddr_cmd_guard`

## Requirements
- R1: After synchronous reset, gnt_valid, refresh_due and every bit of viol_rules are 0.
- R2: A command offered in cycle c with every rule met appears on gnt_valid/gnt_cmd/gnt_bank in cycle c+1. Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 mode register set, 7 self-refresh exit. A no-op, or a cycle with req_valid low, forwards nothing and sets no violation bit. gnt_autopre echoes req_autopre for writes only.
- R3: An activate needs an idle bank. It must come a row cycle (ceil of 55 ns, or 60 ns in the slow grade) after that bank's last activate, and a row-precharge time after its precharge. It must come ceil(10 ns/12 ns) after an activate to any bank and ceil(70 ns/72 ns) after an auto refresh.
- R4: Read and write need an open bank and ceil(15 ns/18 ns) since its activate. A read additionally needs 2 cycles since the last write.
- R5: A precharge to an open bank needs ceil(40 ns/42 ns) since its activate and ceil(15 ns) since its last write. A precharge to an idle bank is legal.
- R6: A write with auto-precharge closes its bank. The next activate to it is allowed ceil(tWR/tCK)+ceil(tRP/tCK) cycles after the write.
- R7: Auto refresh needs every bank idle, every bank past its row-precharge time, a row cycle since every bank's activate, and a refresh recovery since the last refresh.
- R8: refresh_due rises once every ceil(7.8 us) cycles, counting from reset, and falls in the cycle after an auto refresh is forwarded.
- R9: Mode register set needs every bank idle and past row precharge. For 2 cycles after it, no command is forwarded.
- R10: Self-refresh exit needs every bank idle. Reads then wait 200 cycles, and every other command waits ceil(75 ns).
- R11: Each blocked command ORs into viol_rules a bit for every rule it broke. The bits are: 0 precharge before the active minimum, 1 row cycle, 2 refresh recovery, 3 activate-to-access, 4 bank not yet ready after precharge or auto-precharge, 5 cross-bank activate spacing, 6 write recovery, 7 write-to-read, 8 mode-set spacing, 9 self-refresh exit, 10 wrong bank state. The bits never clear until reset.
- R12: A row still open ceil(70,000 ns) cycles after its activate sets viol_rules bit 11.
- R13: A rule of N cycles after a command forwarded from cycle c allows the dependent command from cycle c+N, with N = ceil(ps / CLK_PS). SLOW_GRADE=1 uses 42/60/72/18/12 ns in place of 40/55/70/15/10 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command offered this cycle |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | BANK_W | Target bank |
| req_autopre | input | 1 | Auto-precharge request on a write |
| gnt_valid | output | 1 | Forwarded command valid |
| gnt_cmd | output | 3 | Forwarded command code |
| gnt_bank | output | BANK_W | Forwarded bank |
| gnt_autopre | output | 1 | Forwarded auto-precharge |
| refresh_due | output | 1 | Refresh interval elapsed |
| viol_rules | output | 12 | Sticky blocked-rule bits |

## Verification
The bench uses the slow grade at 10 ns per cycle. At that clock the cross-bank spacing is 2 cycles, so it can be broken. Each rule is probed with one command offered a single cycle early, then the same command offered exactly on its due cycle. The pair tells apart an off-by-one in the cycle conversion or the counter load from a rule that is not checked at all. Mixed sequences (a write then a read, a write then a precharge, auto-precharge writes, refresh with a bank open, mode set, self-refresh exit with reads held back) show that every bit is set alone or together with exactly the other rules that fail.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_SRX = 3'd7
  } cmd_e;

  localparam int NRULE     = 12;
  localparam int RB_RASMIN = 0;
  localparam int RB_RC     = 1;
  localparam int RB_RFC    = 2;
  localparam int RB_RCD    = 3;
  localparam int RB_READY  = 4;
  localparam int RB_RRD    = 5;
  localparam int RB_WR     = 6;
  localparam int RB_WTR    = 7;
  localparam int RB_MRD    = 8;
  localparam int RB_XS     = 9;
  localparam int RB_STATE  = 10;
  localparam int RB_RASMAX = 11;

  // picoseconds to whole cycles, rounding up
  function automatic int ps2ck(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  // counter load for an N-cycle spacing
  function automatic int ld(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_guard_timer.sv
module ddr_guard_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         idle
);
  logic [W-1:0] cnt;
  logic [W-1:0] dec;

  always_comb dec = (cnt != '0) ? cnt - 1'b1 : '0;

  // a new load only ever extends the pending wait
  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load && val > dec) cnt <= val;
    else                       cnt <= dec;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int W        = 16,
  parameter int RAS_L    = 3,
  parameter int RC_L     = 5,
  parameter int RCD_L    = 1,
  parameter int RP_L     = 1,
  parameter int WR_L     = 1,
  parameter int DAL_L    = 3,
  parameter int RASMAX_L = 6999
) (
  input  logic clk,
  input  logic rst,
  input  logic g_act,
  input  logic g_wr,
  input  logic g_pre,
  input  logic autopre,
  output logic open_o,
  output logic rasmin_ok,
  output logic rc_ok,
  output logic rcd_ok,
  output logic ready_ok,
  output logic wr_ok,
  output logic rasmax_hit
);
  localparam logic [W-1:0] RAS_V    = W'(RAS_L);
  localparam logic [W-1:0] RC_V     = W'(RC_L);
  localparam logic [W-1:0] RCD_V    = W'(RCD_L);
  localparam logic [W-1:0] RP_V     = W'(RP_L);
  localparam logic [W-1:0] WR_V     = W'(WR_L);
  localparam logic [W-1:0] DAL_V    = W'(DAL_L);
  localparam logic [W-1:0] RASMAX_V = W'(RASMAX_L);

  logic g_wrap;
  logic open_q;
  logic max_idle;

  assign g_wrap = g_wr && autopre;

  always_ff @(posedge clk) begin
    if (rst)                  open_q <= 1'b0;
    else if (g_act)           open_q <= 1'b1;
    else if (g_pre || g_wrap) open_q <= 1'b0;
  end

  ddr_guard_timer #(.W(W)) u_ras (.clk(clk), .rst(rst), .load(g_act), .val(RAS_V), .idle(rasmin_ok));
  ddr_guard_timer #(.W(W)) u_rc  (.clk(clk), .rst(rst), .load(g_act), .val(RC_V),  .idle(rc_ok));
  ddr_guard_timer #(.W(W)) u_rcd (.clk(clk), .rst(rst), .load(g_act), .val(RCD_V), .idle(rcd_ok));
  ddr_guard_timer #(.W(W)) u_rdy (.clk(clk), .rst(rst), .load(g_pre || g_wrap),
                                  .val(g_wrap ? DAL_V : RP_V), .idle(ready_ok));
  ddr_guard_timer #(.W(W)) u_wr  (.clk(clk), .rst(rst), .load(g_wr), .val(WR_V), .idle(wr_ok));
  ddr_guard_timer #(.W(W)) u_max (.clk(clk), .rst(rst), .load(g_act), .val(RASMAX_V), .idle(max_idle));

  assign open_o     = open_q;
  assign rasmax_hit = open_q && max_idle && !(g_pre || g_wrap);
endmodule

// File: rtl/ddr_refresh_tracker.sv
module ddr_refresh_tracker #(
  parameter int W      = 10,
  parameter int REFI_C = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_g,
  output logic due
);
  localparam logic [W-1:0] TOP = W'(REFI_C - 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= TOP;
      due <= 1'b0;
    end else begin
      cnt <= (cnt == '0) ? TOP : cnt - 1'b1;
      if (cnt == '0)  due <= 1'b1;
      else if (ref_g) due <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int CLK_PS     = 10000,
  parameter int SLOW_GRADE = 0,
  parameter int REFI_PS    = 7800000,
  parameter int RASMAX_PS  = 70000000,
  parameter int WR_PS      = 15000,
  parameter int XSNR_PS    = 75000,
  parameter int XSRD_CK    = 200,
  parameter int WTR_CK     = 2,
  parameter int MRD_CK     = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_autopre,
  output logic              gnt_valid,
  output logic [2:0]        gnt_cmd,
  output logic [BANK_W-1:0] gnt_bank,
  output logic              gnt_autopre,
  output logic              refresh_due,
  output logic [NRULE-1:0]  viol_rules
);
  localparam int RAS_C    = ps2ck(SLOW_GRADE ? 42000 : 40000, CLK_PS);
  localparam int RC_C     = ps2ck(SLOW_GRADE ? 60000 : 55000, CLK_PS);
  localparam int RFC_C    = ps2ck(SLOW_GRADE ? 72000 : 70000, CLK_PS);
  localparam int RCD_C    = ps2ck(SLOW_GRADE ? 18000 : 15000, CLK_PS);
  localparam int RP_C     = ps2ck(SLOW_GRADE ? 18000 : 15000, CLK_PS);
  localparam int RRD_C    = ps2ck(SLOW_GRADE ? 12000 : 10000, CLK_PS);
  localparam int WR_C     = ps2ck(WR_PS, CLK_PS);
  localparam int DAL_C    = WR_C + RP_C;
  localparam int XSNR_C   = ps2ck(XSNR_PS, CLK_PS);
  localparam int RASMAX_C = ps2ck(RASMAX_PS, CLK_PS);
  localparam int REFI_C   = ps2ck(REFI_PS, CLK_PS);
  localparam int MAXC     = imax(imax(imax(RASMAX_C, XSRD_CK), imax(RC_C, RFC_C)),
                                 imax(imax(DAL_C, XSNR_C), imax(WTR_CK, MRD_CK)));
  localparam int TW       = $clog2(MAXC + 1);
  localparam int RW       = $clog2(REFI_C + 1);

  // device-wide timers
  localparam int DEV_N   = 6;
  localparam int DT_RRD  = 0;
  localparam int DT_RFC  = 1;
  localparam int DT_WTR  = 2;
  localparam int DT_MRD  = 3;
  localparam int DT_XSNR = 4;
  localparam int DT_XSRD = 5;

  cmd_e cmd;
  assign cmd = cmd_e'(req_cmd);

  logic [NUM_BANKS-1:0] b_open, b_rasmin, b_rc, b_rcd, b_ready, b_wr, b_max;
  logic [DEV_N-1:0]     dev_load, dev_idle;
  logic [TW-1:0]        dev_val [DEV_N];
  logic [NRULE-1:0]     fail;
  logic                 legal;
  logic                 all_closed, all_ready, all_rc;

  assign all_closed = (b_open == '0);
  assign all_ready  = &b_ready;
  assign all_rc     = &b_rc;

  // legality decision
  always_comb begin
    fail = '0;
    if (req_valid) begin
      case (cmd)
        CMD_ACT: begin
          fail[RB_STATE] = b_open[req_bank];
          fail[RB_RC]    = !b_rc[req_bank];
          fail[RB_READY] = !b_ready[req_bank];
          fail[RB_RRD]   = !dev_idle[DT_RRD];
          fail[RB_RFC]   = !dev_idle[DT_RFC];
          fail[RB_MRD]   = !dev_idle[DT_MRD];
          fail[RB_XS]    = !dev_idle[DT_XSNR];
        end
        CMD_RD: begin
          fail[RB_STATE] = !b_open[req_bank];
          fail[RB_RCD]   = !b_rcd[req_bank];
          fail[RB_WTR]   = !dev_idle[DT_WTR];
          fail[RB_MRD]   = !dev_idle[DT_MRD];
          fail[RB_XS]    = !dev_idle[DT_XSRD];
        end
        CMD_WR: begin
          fail[RB_STATE] = !b_open[req_bank];
          fail[RB_RCD]   = !b_rcd[req_bank];
          fail[RB_MRD]   = !dev_idle[DT_MRD];
          fail[RB_XS]    = !dev_idle[DT_XSNR];
        end
        CMD_PRE: begin
          fail[RB_RASMIN] = b_open[req_bank] && !b_rasmin[req_bank];
          fail[RB_WR]     = b_open[req_bank] && !b_wr[req_bank];
          fail[RB_MRD]    = !dev_idle[DT_MRD];
          fail[RB_XS]     = !dev_idle[DT_XSNR];
        end
        CMD_REF: begin
          fail[RB_STATE] = !all_closed;
          fail[RB_READY] = !all_ready;
          fail[RB_RC]    = !all_rc;
          fail[RB_RFC]   = !dev_idle[DT_RFC];
          fail[RB_MRD]   = !dev_idle[DT_MRD];
          fail[RB_XS]    = !dev_idle[DT_XSNR];
        end
        CMD_MRS: begin
          fail[RB_STATE] = !all_closed;
          fail[RB_READY] = !all_ready;
          fail[RB_MRD]   = !dev_idle[DT_MRD];
          fail[RB_XS]    = !dev_idle[DT_XSNR];
        end
        CMD_SRX: begin
          fail[RB_STATE] = !all_closed;
        end
        default: fail = '0;
      endcase
    end
    legal = req_valid && (cmd != CMD_NOP) && (fail == '0);
  end

  logic act_g, rd_g, wr_g, pre_g, ref_g, mrs_g, srx_g;
  assign act_g = legal && (cmd == CMD_ACT);
  assign rd_g  = legal && (cmd == CMD_RD);
  assign wr_g  = legal && (cmd == CMD_WR);
  assign pre_g = legal && (cmd == CMD_PRE);
  assign ref_g = legal && (cmd == CMD_REF);
  assign mrs_g = legal && (cmd == CMD_MRS);
  assign srx_g = legal && (cmd == CMD_SRX);

  always_comb begin
    dev_load[DT_RRD]  = act_g;  dev_val[DT_RRD]  = TW'(ld(RRD_C));
    dev_load[DT_RFC]  = ref_g;  dev_val[DT_RFC]  = TW'(ld(RFC_C));
    dev_load[DT_WTR]  = wr_g;   dev_val[DT_WTR]  = TW'(ld(WTR_CK));
    dev_load[DT_MRD]  = mrs_g;  dev_val[DT_MRD]  = TW'(ld(MRD_CK));
    dev_load[DT_XSNR] = srx_g;  dev_val[DT_XSNR] = TW'(ld(XSNR_C));
    dev_load[DT_XSRD] = srx_g;  dev_val[DT_XSRD] = TW'(ld(XSRD_CK));
  end

  for (genvar d = 0; d < DEV_N; d++) begin : g_dev
    ddr_guard_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst(rst), .load(dev_load[d]), .val(dev_val[d]), .idle(dev_idle[d])
    );
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit = legal && (req_bank == BANK_W'(i));
    ddr_bank_tracker #(
      .W(TW), .RAS_L(ld(RAS_C)), .RC_L(ld(RC_C)), .RCD_L(ld(RCD_C)), .RP_L(ld(RP_C)),
      .WR_L(ld(WR_C)), .DAL_L(ld(DAL_C)), .RASMAX_L(ld(RASMAX_C))
    ) u_trk (
      .clk(clk), .rst(rst),
      .g_act(hit && (cmd == CMD_ACT)),
      .g_wr(hit && (cmd == CMD_WR)),
      .g_pre(hit && (cmd == CMD_PRE)),
      .autopre(req_autopre),
      .open_o(b_open[i]), .rasmin_ok(b_rasmin[i]), .rc_ok(b_rc[i]), .rcd_ok(b_rcd[i]),
      .ready_ok(b_ready[i]), .wr_ok(b_wr[i]), .rasmax_hit(b_max[i])
    );
  end

  ddr_refresh_tracker #(.W(RW), .REFI_C(REFI_C)) u_refi (
    .clk(clk), .rst(rst), .ref_g(ref_g), .due(refresh_due)
  );

  logic [NRULE-1:0] max_bits;
  always_comb begin
    max_bits = '0;
    max_bits[RB_RASMAX] = |b_max;
  end

  // registered forward path and sticky record
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid   <= 1'b0;
      gnt_cmd     <= 3'd0;
      gnt_bank    <= '0;
      gnt_autopre <= 1'b0;
      viol_rules  <= '0;
    end else begin
      gnt_valid   <= legal;
      gnt_cmd     <= req_cmd;
      gnt_bank    <= req_bank;
      gnt_autopre <= req_autopre && (cmd == CMD_WR);
      viol_rules  <= viol_rules | fail | max_bits;
    end
  end

  // rd_g is part of the decode set; reads load no timer of their own
  logic unused_rd;
  assign unused_rd = rd_g;
endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic              gnt_valid,
  input logic [2:0]        gnt_cmd,
  input logic [BANK_W-1:0] gnt_bank,
  input logic              gnt_autopre,
  input logic [NRULE-1:0]  viol_rules
);
  // bank state rebuilt from the forwarded stream alone
  logic [NUM_BANKS-1:0] open_q;
  always_ff @(posedge clk) begin
    if (rst) open_q <= '0;
    else if (gnt_valid) begin
      if (gnt_cmd == CMD_ACT) open_q[gnt_bank] <= 1'b1;
      else if (gnt_cmd == CMD_PRE || (gnt_cmd == CMD_WR && gnt_autopre)) open_q[gnt_bank] <= 1'b0;
    end
  end

  // R2
  p_fwd_match_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ($past(req_valid) && $past(req_cmd) == gnt_cmd && $past(req_bank) == gnt_bank));

  // R2
  p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_cmd == CMD_NOP) |=> !gnt_valid);

  // R3
  p_act_idle_bank_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && gnt_cmd == CMD_ACT) |-> !open_q[gnt_bank]);

  // R4
  p_access_open_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && (gnt_cmd == CMD_RD || gnt_cmd == CMD_WR)) |-> open_q[gnt_bank]);

  // R7
  p_all_closed_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && (gnt_cmd == CMD_REF || gnt_cmd == CMD_MRS || gnt_cmd == CMD_SRX)) |-> (open_q == '0));

  // R11
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (viol_rules & $past(viol_rules)) == $past(viol_rules));
endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/ddr_cmd_guard_tb_top.sv
module ddr_cmd_guard_tb_top;
  import ddr_guard_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [2:0]       req_cmd = 3'd0;
  logic [1:0]       req_bank = 2'd0;
  logic             req_autopre = 1'b0;
  logic             gnt_valid, gnt_autopre, refresh_due;
  logic [2:0]       gnt_cmd;
  logic [1:0]       gnt_bank;
  logic [NRULE-1:0] viol_rules;

  ddr_cmd_guard #(.NUM_BANKS(4), .CLK_PS(10000), .SLOW_GRADE(1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_autopre(req_autopre), .gnt_valid(gnt_valid), .gnt_cmd(gnt_cmd), .gnt_bank(gnt_bank),
    .gnt_autopre(gnt_autopre), .refresh_due(refresh_due), .viol_rules(viol_rules)
  );

  typedef struct {
    logic       exp_g;
    logic [2:0] cmd;
    logic [1:0] bank;
    logic       ap;
    string      tag;
  } item_t;

  item_t            sb_q[$];
  int               n_chk = 0;
  int               n_bad = 0;
  logic [NRULE-1:0] exp_viol = '0;
  logic             chk_pend = 1'b0;

  function automatic logic [NRULE-1:0] rb(input int i);
    logic [NRULE-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // monitor: compare the forwarded command with the scoreboard
  always @(posedge clk) chk_pend <= req_valid;
  always @(negedge clk) begin
    if (chk_pend && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (gnt_valid !== it.exp_g ||
          (it.exp_g && (gnt_cmd !== it.cmd || gnt_bank !== it.bank || gnt_autopre !== it.ap))) begin
        n_bad++;
        $display("FAIL %s: gnt=%0b cmd=%0d bank=%0d ap=%0b, expected gnt=%0b cmd=%0d bank=%0d ap=%0b",
                 it.tag, gnt_valid, gnt_cmd, gnt_bank, gnt_autopre,
                 it.exp_g, it.cmd, it.bank, it.ap);
      end
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_viol(input string tag);
    n_chk++;
    if (viol_rules !== exp_viol) begin
      n_bad++;
      $display("FAIL %s: viol_rules=%b expected %b", tag, viol_rules, exp_viol);
    end
  endtask

  // driver: one command per cycle, expectation pushed alongside
  task automatic issue(input cmd_e c, input int b, input logic ap, input logic exp_g,
                       input logic [NRULE-1:0] bits, input string tag);
    item_t it;
    req_valid   = 1'b1;
    req_cmd     = c;
    req_bank    = b[1:0];
    req_autopre = ap;
    it.exp_g = exp_g; it.cmd = c; it.bank = b[1:0]; it.ap = ap && (c == CMD_WR); it.tag = tag;
    sb_q.push_back(it);
    exp_viol = exp_viol | bits;
    @(negedge clk);
    req_valid   = 1'b0;
    req_cmd     = 3'd0;
    req_autopre = 1'b0;
    if (!exp_g) check_viol(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(100000 * 10);
    n_bad++;
    $display("FAIL R2: watchdog expired, got no end of run, expected end of run");
    finish_run();
  end

  // slow grade at 10 ns: RAS 5, RC 6, RFC 8, RCD 2, RP 2, RRD 2, WR 2, WTR 2, MRD 2, DAL 4, XSNR 8, XSRD 200
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R1 reset gnt_valid", gnt_valid, 1'b0);
    check_bit("R1 reset refresh_due", refresh_due, 1'b0);
    check_viol("R1 reset viol_rules");

    idle(700);
    check_bit("R8 refresh_due before interval", refresh_due, 1'b0);
    idle(100);
    check_bit("R8 refresh_due after interval", refresh_due, 1'b1);
    issue(CMD_REF, 0, 1'b0, 1'b1, '0, "R7 refresh with all banks idle");
    check_bit("R8 refresh_due cleared by refresh", refresh_due, 1'b0);
    issue(CMD_NOP, 0, 1'b0, 1'b0, '0, "R2 no-op not forwarded");
    idle(10);

    // c0
    issue(CMD_ACT, 0, 1'b0, 1'b1, '0, "R3 activate bank0");
    issue(CMD_ACT, 1, 1'b0, 1'b0, rb(RB_RRD), "R3 cross-bank activate one cycle early");
    issue(CMD_RD, 0, 1'b0, 1'b1, '0, "R4 read at activate-to-access");
    issue(CMD_RD, 1, 1'b0, 1'b0, rb(RB_STATE), "R4 read to idle bank");
    issue(CMD_PRE, 0, 1'b0, 1'b0, rb(RB_RASMIN), "R5 precharge before active minimum");
    issue(CMD_PRE, 0, 1'b0, 1'b1, '0, "R5 precharge at active minimum");
    issue(CMD_ACT, 0, 1'b0, 1'b0, rb(RB_READY), "R3 activate before row precharge");
    // c1
    issue(CMD_ACT, 0, 1'b0, 1'b1, '0, "R13 activate exactly at row precharge");
    issue(CMD_WR, 0, 1'b0, 1'b0, rb(RB_RCD), "R4 write before activate-to-access");
    issue(CMD_WR, 0, 1'b0, 1'b1, '0, "R4 write granted");
    issue(CMD_RD, 0, 1'b0, 1'b0, rb(RB_WTR), "R4 read one cycle after write");
    issue(CMD_RD, 0, 1'b0, 1'b1, '0, "R4 read two cycles after write");
    issue(CMD_WR, 0, 1'b0, 1'b1, '0, "R4 second write");
    issue(CMD_PRE, 0, 1'b0, 1'b0, rb(RB_WR), "R5 precharge inside write recovery");
    issue(CMD_PRE, 0, 1'b0, 1'b1, '0, "R5 precharge after write recovery");
    idle(1);
    // c2
    issue(CMD_ACT, 0, 1'b0, 1'b1, '0, "R3 reactivate bank0");
    idle(3);
    issue(CMD_WR, 0, 1'b1, 1'b1, '0, "R6 write with auto-precharge");
    idle(1);
    issue(CMD_ACT, 0, 1'b0, 1'b0, rb(RB_READY), "R6 activate before auto-precharge done");
    idle(1);
    // c3
    issue(CMD_ACT, 0, 1'b0, 1'b1, '0, "R6 activate at write plus tWR plus tRP");
    issue(CMD_REF, 0, 1'b0, 1'b0, rb(RB_STATE) | rb(RB_RC), "R7 refresh with open bank");
    idle(3);
    issue(CMD_PRE, 0, 1'b0, 1'b1, '0, "R5 precharge bank0");
    issue(CMD_REF, 0, 1'b0, 1'b0, rb(RB_READY), "R7 refresh inside row precharge");
    // r
    issue(CMD_REF, 0, 1'b0, 1'b1, '0, "R7 refresh granted");
    issue(CMD_ACT, 1, 1'b0, 1'b0, rb(RB_RFC), "R3 activate inside refresh recovery");
    issue(CMD_REF, 0, 1'b0, 1'b0, rb(RB_RFC), "R7 refresh inside refresh recovery");
    idle(5);
    // a = r+8
    issue(CMD_ACT, 1, 1'b0, 1'b1, '0, "R3 activate after refresh recovery");
    idle(4);
    issue(CMD_PRE, 1, 1'b0, 1'b1, '0, "R5 precharge bank1");
    issue(CMD_MRS, 0, 1'b0, 1'b0, '0, "R9 mode set inside row precharge");
    // m
    issue(CMD_MRS, 0, 1'b0, 1'b1, '0, "R9 mode set granted");
    issue(CMD_ACT, 2, 1'b0, 1'b0, rb(RB_MRD), "R9 activate one cycle after mode set");
    issue(CMD_ACT, 2, 1'b0, 1'b1, '0, "R9 activate two cycles after mode set");
    idle(4);
    issue(CMD_PRE, 2, 1'b0, 1'b1, '0, "R5 precharge bank2");
    // s
    issue(CMD_SRX, 0, 1'b0, 1'b1, '0, "R10 self-refresh exit");
    issue(CMD_ACT, 3, 1'b0, 1'b0, rb(RB_XS), "R10 activate right after exit");
    idle(6);
    issue(CMD_ACT, 3, 1'b0, 1'b1, '0, "R10 activate at exit non-read time");
    idle(1);
    issue(CMD_RD, 3, 1'b0, 1'b0, '0, "R10 read before 200 cycles");
    idle(189);
    issue(CMD_RD, 3, 1'b0, 1'b1, '0, "R10 read at 200 cycles");
    check_viol("R12 no open-row flag early");

    idle(7100);
    exp_viol = exp_viol | rb(RB_RASMAX);
    check_viol("R12 open-row maximum exceeded");
    check_bit("R11 open-row bit kept", viol_rules[RB_RASMAX], 1'b1);
    finish_run();
  end
endmodule